// File: doc/BRIEF.md
# Bus cycle wait-state inserter

This block stands between a processor core or DMA engine and the external bus. For each bus access it works out how many wait clocks the access needs. The count depends on the kind of access and on a small wait-control register. Memory-type accesses take their count from one 2-bit field. External I/O accesses take theirs from a second 2-bit field, plus one. An I/O address that falls inside a 64-byte window of on-chip control registers is handled internally. Such an access has no wait clocks and raises an internal-select strobe, so it is not sent to the external bus.

The requester pulses `acc_valid` for one clock with the access kind and, for I/O, the address. The block then holds `stall` high for the computed number of wait clocks and raises `done` for one clock to complete the access. The wait-control value is captured when the access is accepted. Writing the register while an access is under way therefore only affects later accesses. The window base is a plain input, and the block does not hold the contents of the on-chip registers.

Top module: `bus_wait_gen`

## Requirements
- R1: For memory read (kind code 0), memory write (code 1) and opcode fetch (code 2), the wait count equals the memory field, which is `wctl_din[3:2]` as last written (0 to 3).
- R2: For an I/O read (code 4) or I/O write (code 5) whose address is outside the internal window, the wait count equals the I/O field `wctl_din[1:0]` plus one (1 to 4), and `int_sel` stays low.
- R3: An I/O access is internal when `io_addr` and `win_base` agree in bits [15:6]. An internal access has zero wait clocks, and `int_sel` is high in the same single clock as `done`.
- R4: A 16-bit immediate operand fetch (code 3) waits twice the memory field (0 to 6).
- R5: An idle burn cycle (code 6) lasts 3 plus the memory field clocks, counting the completing clock, which gives 2 plus the memory field wait clocks.
- R6: In the clocks after the accepting edge, `stall` is high for exactly the wait count, then `done` is high for one clock with `stall` low. A zero count gives `done` in the first clock after the strobe, with no stall.
- R7: The access uses the wait-control value held at the accepting edge. A write on that same edge, or a write during the stall, applies from the next access onward.
- R8: After reset the wait-control value is all ones, so a memory access waits 3 clocks and an external I/O access waits 4. `stall`, `done` and `int_sel` are low.
- R9: A strobe that arrives while `stall` is high is ignored. The current access ends on schedule, and no further `done` follows it.
- R10: Kind code 7 is reserved. It completes with zero wait clocks and `int_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | One-clock access strobe; accepted when `stall` is low |
| acc_kind | input | 3 | Access kind code (see R1 to R10) |
| io_addr | input | 16 | I/O address of the access |
| win_base | input | 16 | Base of the internal register window |
| wctl_we | input | 1 | Wait-control register write enable |
| wctl_din | input | 4 | New wait-control value: [3:2] memory field, [1:0] I/O field |
| stall | output | 1 | High during wait clocks |
| done | output | 1 | One-clock completion of the access |
| int_sel | output | 1 | Internal-register select, coincident with `done` |

## Verification
Two functions can fall on the same clock edge: a write to the wait-control register, and the acceptance of a new access. The bench provokes this by driving `wctl_we` together with `acc_valid`, and also by writing the register on the first stall clock. It judges the outcome by counting stall clocks: the current access must use the old field values, and the following access must use the new ones. A second overlap, a strobe arriving while `stall` is high, is checked by confirming that the wait count does not change and that no second `done` appears.

// File: rtl/bwait_pkg.sv
package bwait_pkg;

    typedef enum logic [2:0] {
        K_MRD  = 3'd0,
        K_MWR  = 3'd1,
        K_OPF  = 3'd2,
        K_IMM  = 3'd3,
        K_IRD  = 3'd4,
        K_IWR  = 3'd5,
        K_BURN = 3'd6,
        K_RSV  = 3'd7
    } acc_kind_e;

    // Largest wait count any access kind can produce.
    function automatic int max_wait(input int field_w, input int burn_clks);
        int fmax;
        int m;
        fmax = (1 << field_w) - 1;
        m    = 2 * fmax;
        if (fmax + 1 > m)             m = fmax + 1;
        if (burn_clks - 1 + fmax > m) m = burn_clks - 1 + fmax;
        return m;
    endfunction

    function automatic logic is_mem_kind(input acc_kind_e k);
        return (k == K_MRD) || (k == K_MWR) || (k == K_OPF);
    endfunction

    function automatic logic is_io_kind(input acc_kind_e k);
        return (k == K_IRD) || (k == K_IWR);
    endfunction

endpackage

// File: rtl/win_decode.sv
module win_decode #(
    parameter int ADDR_W  = 16,
    parameter int WIN_LSB = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'((64'd1 << WIN_LSB) - 64'd1);
    localparam logic [ADDR_W-1:0] MASK     = ~LOW_ONES;

    always_comb begin
        hit = (((addr ^ base) & MASK) == '0);
    end
endmodule

// File: rtl/wait_calc.sv
module wait_calc
    import bwait_pkg::*;
#(
    parameter int FIELD_W   = 2,
    parameter int BURN_CLKS = 3,
    parameter int CNT_W     = 3
) (
    input  acc_kind_e          kind,
    input  logic               is_int,
    input  logic [FIELD_W-1:0] mem_f,
    input  logic [FIELD_W-1:0] io_f,
    output logic [CNT_W-1:0]   n,
    output logic               isel
);
    localparam logic [CNT_W-1:0] BURN_EXTRA = CNT_W'(BURN_CLKS - 1);

    logic [CNT_W-1:0] mem_n;
    logic [CNT_W-1:0] io_n;

    always_comb begin
        mem_n = CNT_W'(mem_f);
        io_n  = CNT_W'(io_f);
        n     = '0;
        isel  = 1'b0;
        unique case (kind)
            K_MRD, K_MWR, K_OPF: n = mem_n;
            K_IMM:               n = mem_n + mem_n;
            K_IRD, K_IWR: begin
                if (is_int) isel = 1'b1;
                else        n    = io_n + CNT_W'(1);
            end
            K_BURN:              n = BURN_EXTRA + mem_n;
            default:             n = '0;
        endcase
    end
endmodule

// File: rtl/wait_seq.sv
module wait_seq #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [CNT_W-1:0] n,
    input  logic             isel_req,
    output logic             stall,
    output logic             done,
    output logic             int_sel
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stall;
        logic             done;
        logic             isel;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.isel = 1'b0;
        if (st_q.stall) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.stall = 1'b0;
                st_d.done  = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (acc_valid) begin
            if (n == '0) begin
                st_d.done = 1'b1;
                st_d.isel = isel_req;
            end else begin
                st_d.stall = 1'b1;
                st_d.cnt   = n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall   = st_q.stall;
    assign done    = st_q.done;
    assign int_sel = st_q.isel;

    // R6: the end of a stall is always the completing clock
    p_stall_ends_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> done);

    // R6: a zero-wait accept completes on the next clock
    p_zero_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !stall && n == '0) |=> (done && !stall));

    // R9: a strobe during a stall does not restart or abort the access
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && acc_valid) |=> (stall || done));

    // R3: internal select only appears as the completing clock
    p_isel_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> (done && !stall));
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
    import bwait_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_LSB   = 6,
    parameter int FIELD_W   = 2,
    parameter int BURN_CLKS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [2:0]           acc_kind,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic [ADDR_W-1:0]    win_base,
    input  logic                 wctl_we,
    input  logic [2*FIELD_W-1:0] wctl_din,
    output logic                 stall,
    output logic                 done,
    output logic                 int_sel
);
    localparam int CTL_W = 2 * FIELD_W;
    localparam int MAXW  = max_wait(FIELD_W, BURN_CLKS);
    localparam int CNT_W = $clog2(MAXW + 1);

    typedef struct packed {
        logic [CTL_W-1:0] wctl;
    } top_st_t;

    top_st_t st_d, st_q;

    acc_kind_e          kind_e;
    logic               win_hit;
    logic [CNT_W-1:0]   wait_n;
    logic               isel_req;
    logic [FIELD_W-1:0] mem_f;
    logic [FIELD_W-1:0] io_f;
    logic               accept;

    always_comb begin
        st_d = st_q;
        if (wctl_we) st_d.wctl = wctl_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{wctl: '1};
        else        st_q <= st_d;
    end

    assign kind_e = acc_kind_e'(acc_kind);
    assign mem_f  = st_q.wctl[CTL_W-1 -: FIELD_W];
    assign io_f   = st_q.wctl[FIELD_W-1:0];
    assign accept = acc_valid && !stall;

    win_decode #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_win (
        .addr (io_addr),
        .base (win_base),
        .hit  (win_hit)
    );

    wait_calc #(.FIELD_W(FIELD_W), .BURN_CLKS(BURN_CLKS), .CNT_W(CNT_W)) u_calc (
        .kind   (kind_e),
        .is_int (win_hit),
        .mem_f  (mem_f),
        .io_f   (io_f),
        .n      (wait_n),
        .isel   (isel_req)
    );

    wait_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .n         (wait_n),
        .isel_req  (isel_req),
        .stall     (stall),
        .done      (done),
        .int_sel   (int_sel)
    );

    // R1: a memory access with a nonzero field stalls
    p_mem_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_mem_kind(kind_e) && mem_f != '0) |=> (stall && !int_sel));

    // R2: external I/O always waits at least one clock
    p_io_ext_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_io_kind(kind_e) && !win_hit) |=> (stall && !int_sel));

    // R3: internal I/O completes at once with the internal strobe
    p_io_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_io_kind(kind_e) && win_hit) |=> (done && int_sel));

    // R5: a burn cycle always stalls
    p_burn_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind_e == K_BURN) |=> stall);

    // R10: reserved kind completes at once without internal select
    p_rsv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind_e == K_RSV) |=> (done && !int_sel));
endmodule

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_kind = 3'd0;
    logic [15:0] io_addr = 16'h0;
    logic [15:0] win_base = 16'h0;
    logic        wctl_we = 1'b0;
    logic [3:0]  wctl_din = 4'h0;
    logic        stall, done, int_sel;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    logic [3:0] model;

    always #2 clk = ~clk;

    bus_wait_gen u_bus_wait_gen (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .io_addr(io_addr), .win_base(win_base), .wctl_we(wctl_we),
        .wctl_din(wctl_din), .stall(stall), .done(done), .int_sel(int_sel)
    );

    function automatic bit in_win(input logic [15:0] a, input logic [15:0] b);
        return ((a ^ b) & 16'hFFC0) == 16'h0;
    endfunction

    function automatic int exp_wait(input logic [2:0] k, input logic [15:0] a,
                                    input logic [15:0] b, input logic [3:0] w);
        int m = int'(w[3:2]);
        int i = int'(w[1:0]);
        case (k)
            3'd0, 3'd1, 3'd2: return m;
            3'd3:             return 2 * m;
            3'd4, 3'd5:       return in_win(a, b) ? 0 : i + 1;
            3'd6:             return 2 + m;
            default:          return 0;
        endcase
    endfunction

    function automatic bit exp_isel(input logic [2:0] k, input logic [15:0] a,
                                    input logic [15:0] b);
        return (k == 3'd4 || k == 3'd5) && in_win(a, b);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_wctl(input logic [3:0] v);
        @(negedge clk);
        wctl_we = 1'b1; wctl_din = v;
        @(negedge clk);
        wctl_we = 1'b0;
        model = v;
    endtask

    // same_w: write wv on the accepting edge; mid_w: write wv on first stall
    // clock; poke: strobe again on first stall clock
    task automatic do_acc(input logic [2:0] k, input logic [15:0] a, input logic [15:0] b,
                          input string req, input bit same_w, input bit mid_w,
                          input bit poke, input logic [3:0] wv);
        int  en;
        bit  ei;
        int  n = 0;
        bit  drove = 0;
        en = exp_wait(k, a, b, model);
        ei = exp_isel(k, a, b);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = k; io_addr = a; win_base = b;
        if (same_w) begin wctl_we = 1'b1; wctl_din = wv; end
        @(negedge clk);
        acc_valid = 1'b0; wctl_we = 1'b0;
        if (same_w) model = wv;
        for (int g = 0; g < 64; g++) begin
            if (done) break;
            if (stall) n++;
            if (stall && !drove && (mid_w || poke)) begin
                drove = 1;
                if (mid_w) begin wctl_we = 1'b1; wctl_din = wv; end
                if (poke)  begin acc_valid = 1'b1; acc_kind = 3'd0; end
            end
            @(negedge clk);
            wctl_we = 1'b0; acc_valid = 1'b0;
        end
        if (drove && mid_w) model = wv;
        chk(done == 1'b1, req, int'(done), 1);
        chk(n == en, req, n, en);
        chk(int_sel == ei && stall == 1'b0, req, int'(int_sel), int'(ei));
        @(negedge clk);
        chk(done == 1'b0 && stall == 1'b0, req, int'(done) + int'(stall), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset outputs idle, slowest timing
        chk(stall == 0 && done == 0 && int_sel == 0, "R8", int'(stall) + int'(done), 0);
        do_acc(3'd0, 16'h0, 16'h0, "R8", 0, 0, 0, 4'h0);
        do_acc(3'd5, 16'h0100, 16'h0000, "R8", 0, 0, 0, 4'h0);
        // R1 / R6 zero waits, R2 minimal I/O wait
        wr_wctl(4'h0);
        do_acc(3'd0, 16'h0, 16'h0, "R6", 0, 0, 0, 4'h0);
        do_acc(3'd4, 16'h0500, 16'h0000, "R2", 0, 0, 0, 4'h0);
        wr_wctl(4'b1001);
        do_acc(3'd1, 16'h0, 16'h0, "R1", 0, 0, 0, 4'h0);
        do_acc(3'd2, 16'h0, 16'h0, "R1", 0, 0, 0, 4'h0);
        do_acc(3'd4, 16'h8000, 16'h0000, "R2", 0, 0, 0, 4'h0);
        // R3 window edges
        do_acc(3'd4, 16'h127F, 16'h1240, "R3", 0, 0, 0, 4'h0);
        do_acc(3'd5, 16'h1240, 16'h127F, "R3", 0, 0, 0, 4'h0);
        do_acc(3'd5, 16'h1280, 16'h1240, "R3", 0, 0, 0, 4'h0);
        do_acc(3'd4, 16'h1200, 16'h1240, "R3", 0, 0, 0, 4'h0);
        // R4 and R5
        do_acc(3'd3, 16'h0, 16'h0, "R4", 0, 0, 0, 4'h0);
        wr_wctl(4'b1100);
        do_acc(3'd3, 16'h0, 16'h0, "R4", 0, 0, 0, 4'h0);
        do_acc(3'd6, 16'h0, 16'h0, "R5", 0, 0, 0, 4'h0);
        wr_wctl(4'b0011);
        do_acc(3'd6, 16'h0, 16'h0, "R5", 0, 0, 0, 4'h0);
        // R10 reserved
        do_acc(3'd7, 16'h1240, 16'h1240, "R10", 0, 0, 0, 4'h0);
        // R7 write on the accepting edge, then during a stall
        wr_wctl(4'h0);
        do_acc(3'd0, 16'h0, 16'h0, "R7", 1, 0, 0, 4'b1100);
        do_acc(3'd0, 16'h0, 16'h0, "R7", 0, 0, 0, 4'h0);
        wr_wctl(4'b1000);
        do_acc(3'd0, 16'h0, 16'h0, "R7", 0, 1, 0, 4'b0100);
        do_acc(3'd1, 16'h0, 16'h0, "R7", 0, 0, 0, 4'h0);
        // R9 strobe during stall
        wr_wctl(4'hF);
        do_acc(3'd0, 16'h0, 16'h0, "R9", 0, 0, 1, 4'h0);
        do_acc(3'd5, 16'h2000, 16'h0000, "R9", 0, 0, 1, 4'h0);
        // random mix
        for (int r = 0; r < 300; r++) begin
            logic [2:0]  k = 3'($urandom % 8);
            logic [15:0] b = 16'($urandom);
            logic [15:0] a = ($urandom % 2 == 0) ? (b ^ 16'($urandom % 64)) : 16'($urandom);
            if ($urandom % 4 == 0) wr_wctl(4'($urandom));
            if ($urandom % 8 == 0)
                do_acc(k, a, b, "R7", 1, 0, 0, 4'($urandom));
            else
                do_acc(k, a, b, "R1", 0, 0, 0, 4'h0);
        end
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule